// File: doc/BRIEF.md
# Serial ADC Sample Capture

This block reads one sample from an external serial analog-to-digital converter in each conversion frame. A request on `start` opens a frame. The block drives the converter's active-low chip select low and toggles a serial clock that it divides down from the system clock. It then shifts in a fixed-length frame, most significant bit first. The frame opens with a number of guard bits that should read zero, and the sample follows them. At the end of the frame the block presents the raw sample. It also presents a copy sign-extended to the downstream word width, together with a one-cycle valid strobe and a flag that is set when any guard bit was non-zero.

The serial clock idles high. The converter is expected to change its data after a falling edge of the serial clock. The block takes each bit on the following rising edge. After the last bit, chip select rises and stays high for a programmable number of half periods before another frame may begin. A request that arrives while a frame or its guard gap is in progress is remembered, and it opens one frame as soon as the block is idle again.

The control state machine has five states:
- IDLE: chip select high, clock high.
- SETUP: chip select low, lasting one half period before the first clock edge.
- CLK_LO: the low half of a serial clock period.
- CLK_HI: the high half of a serial clock period.
- GAP: chip select high after the frame.

The state machine has the following transitions:
- IDLE→SETUP on a request or a remembered request.
- SETUP→CLK_LO after one half period.
- CLK_LO→CLK_HI after one half period, taking a bit.
- CLK_HI→CLK_LO after one half period while bits remain.
- CLK_HI→GAP after one half period once the last bit has been taken. The output word is loaded on this transition.
- GAP→IDLE after the gap half periods have elapsed.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `adc_cs_n` and `adc_sclk` are 1, and `sample_vld`, `lead_err`, `sample_raw` and `sample_word` are 0.
- R2: A `start` sampled high in IDLE drives `adc_cs_n` low after that edge. `adc_sclk` stays high for HALF_DIV system cycles before its first fall.
- R3: A frame has exactly FRAME_BITS (16) serial clock periods. Each period is HALF_DIV cycles low followed by HALF_DIV cycles high. `adc_cs_n` stays low for the whole frame, and `adc_sclk` never toggles while `adc_cs_n` is high.
- R4: The bit taken on rising edge k (k = 0..15) is frame bit 15−k, so the frame is received MSB first. `sample_raw` equals frame bits [11:0].
- R5: `sample_word[11:0]` equals `sample_raw`, and `sample_word[15:12]` each equal `sample_raw[11]` (two's-complement sign extension).
- R6: `sample_vld` is high for exactly one cycle per frame. That cycle is 33·HALF_DIV cycles after the start edge, and it is the first cycle with `adc_cs_n` high again.
- R7: After a frame, `adc_cs_n` stays high for at least GAP_HALVES·HALF_DIV (4) cycles before it falls again.
- R8: A `start` sampled while the block is not in IDLE is held. One frame begins on the edge after the block returns to IDLE, and several requests during one busy period open only one extra frame.
- R9: `lead_err` is 1 when any of frame bits [15:12] is 1. It updates together with `sample_vld`, and `lead_err`, `sample_raw` and `sample_word` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low converter chip select |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| sample_raw | output | 12 | Captured sample bits |
| sample_word | output | 16 | Sign-extended sample |
| sample_vld | output | 1 | One-cycle strobe for a new word |
| lead_err | output | 1 | Guard bits were not all zero |

## Verification
Take the edge that samples `start` in IDLE as cycle 0, with H = HALF_DIV:
- Chip select is due low one cycle later.
- The first clock fall is due at cycle H.
- Bit k is captured at edge 2(k+1)·H.
- The word, the flag and the strobe are due at cycle 33·H.
- Idle returns at cycle 35·H, so a held request opens its frame at cycle 35·H+1.

The bench model advances an integer cycle count from the same start edge and predicts every output for the cycle after each edge. All outputs are compared half a clock later, so each expectation is checked in exactly the cycle the requirement gives.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP
    } rd_state_t;

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int GAP_HALVES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic run,
    output logic take,
    output logic frame_end,
    output logic cs_n,
    output logic sclk
);
    localparam int BCW = $clog2(FRAME_BITS + 1);
    localparam int GCW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [BCW-1:0] BITS_ALL = BCW'(FRAME_BITS);
    localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_HALVES - 1);

    rd_state_t     state, nxt;
    logic [BCW-1:0] bit_cnt;
    logic [GCW-1:0] gap_cnt;
    logic           pend;
    logic           go;

    assign go        = start || pend;
    assign run       = (state != ST_IDLE);
    assign take      = (state == ST_CLK_LO) && tick;
    assign frame_end = (state == ST_CLK_HI) && tick && (bit_cnt == BITS_ALL);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_SETUP;
            ST_SETUP:  if (tick) nxt = ST_CLK_LO;
            ST_CLK_LO: if (tick) nxt = ST_CLK_HI;
            ST_CLK_HI: if (tick) nxt = (bit_cnt == BITS_ALL) ? ST_GAP : ST_CLK_LO;
            ST_GAP:    if (tick && gap_cnt == GAP_LAST) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            gap_cnt <= '0;
            pend    <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                pend <= 1'b0;
            else if (start)
                pend <= 1'b1;
            if (state == ST_IDLE)
                bit_cnt <= '0;
            else if (take)
                bit_cnt <= bit_cnt + BCW'(1);
            if (state != ST_GAP)
                gap_cnt <= '0;
            else if (tick)
                gap_cnt <= gap_cnt + GCW'(1);
        end
    end

    // registered pin outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
        end else begin
            cs_n <= (nxt == ST_IDLE) || (nxt == ST_GAP);
            sclk <= (nxt != ST_CLK_LO);
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int FRAME_BITS = 16,
    parameter int LEAD_BITS  = 4,
    parameter int OUT_BITS   = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               take,
    input  logic                               sdi,
    input  logic                               load,
    output logic [FRAME_BITS-LEAD_BITS-1:0]    raw,
    output logic [OUT_BITS-1:0]                word,
    output logic                               lead_err,
    output logic                               vld
);
    localparam int SAMPLE_BITS = FRAME_BITS - LEAD_BITS;
    localparam int EXT_BITS    = OUT_BITS - SAMPLE_BITS;

    logic [FRAME_BITS-1:0] sh;
    logic [OUT_BITS-1:0]   word_d;

    generate
        if (EXT_BITS > 0) begin : g_ext
            assign word_d = {{EXT_BITS{sh[SAMPLE_BITS-1]}}, sh[SAMPLE_BITS-1:0]};
        end else begin : g_trunc
            assign word_d = sh[OUT_BITS-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '0;
        else if (take)
            sh <= {sh[FRAME_BITS-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw      <= '0;
            word     <= '0;
            lead_err <= 1'b0;
            vld      <= 1'b0;
        end else begin
            vld <= load;
            if (load) begin
                raw      <= sh[SAMPLE_BITS-1:0];
                word     <= word_d;
                lead_err <= |sh[FRAME_BITS-1:SAMPLE_BITS];
            end
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 16,
    parameter int LEAD_BITS  = 4,
    parameter int OUT_BITS   = 16,
    parameter int GAP_HALVES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               adc_sdo,
    output logic                               adc_cs_n,
    output logic                               adc_sclk,
    output logic [FRAME_BITS-LEAD_BITS-1:0]    sample_raw,
    output logic [OUT_BITS-1:0]                sample_word,
    output logic                               sample_vld,
    output logic                               lead_err
);
    logic run, tick, take, frame_end;

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_rd_ctrl #(.FRAME_BITS(FRAME_BITS), .GAP_HALVES(GAP_HALVES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .run       (run),
        .take      (take),
        .frame_end (frame_end),
        .cs_n      (adc_cs_n),
        .sclk      (adc_sclk)
    );

    adc_rd_shift #(
        .FRAME_BITS (FRAME_BITS),
        .LEAD_BITS  (LEAD_BITS),
        .OUT_BITS   (OUT_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .sdi      (adc_sdo),
        .load     (frame_end),
        .raw      (sample_raw),
        .word     (sample_word),
        .lead_err (lead_err),
        .vld      (sample_vld)
    );
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
    parameter int HALF_DIV   = 2,
    parameter int GAP_HALVES = 2,
    parameter int RAW_BITS   = 12,
    parameter int OUT_BITS   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                adc_cs_n,
    input logic                adc_sclk,
    input logic [RAW_BITS-1:0] sample_raw,
    input logic [OUT_BITS-1:0] sample_word,
    input logic                sample_vld,
    input logic                lead_err
);
    localparam int MIN_HIGH = GAP_HALVES * HALF_DIV;

    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= 0;
        else if (!adc_cs_n)
            hi_cnt <= 0;
        else if (hi_cnt < 32'hFFFF)
            hi_cnt <= hi_cnt + 1;
    end

    assert_vld_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> adc_cs_n);

    assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    assert_cs_rise_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> sample_vld);

    assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_sclk) || $fell(adc_sclk)) |-> !adc_cs_n);

    assert_setup_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> adc_sclk);

    assert_gap_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hi_cnt >= MIN_HIGH));

    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> ($stable(sample_word) && $stable(sample_raw) && $stable(lead_err)));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .HALF_DIV   (HALF_DIV),
    .GAP_HALVES (GAP_HALVES),
    .RAW_BITS   (FRAME_BITS - LEAD_BITS),
    .OUT_BITS   (OUT_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .sample_raw  (sample_raw),
    .sample_word (sample_word),
    .sample_vld  (sample_vld),
    .lead_err    (lead_err)
);

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps
module adc_frame_reader_bench;
    localparam int H      = 2;
    localparam int GAPH   = 2;
    localparam int T_END  = 33 * H;
    localparam int T_IDLE = T_END + GAPH * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        adc_sdo = 1'b0;
    logic        adc_cs_n, adc_sclk, sample_vld, lead_err;
    logic [11:0] sample_raw;
    logic [15:0] sample_word;

    always #2 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(H), .GAP_HALVES(GAPH)) u_adc_frame_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .adc_sdo     (adc_sdo),
        .adc_cs_n    (adc_cs_n),
        .adc_sclk    (adc_sclk),
        .sample_raw  (sample_raw),
        .sample_word (sample_word),
        .sample_vld  (sample_vld),
        .lead_err    (lead_err)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int vld_seen = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // converter model: new bit after each falling serial clock edge
    logic [15:0] word_q[$];
    logic [15:0] conv_word = '0;
    int          fcnt = 0;
    logic        prev_sclk = 1'b1, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (adc_cs_n) begin
            fcnt = 0;
        end else begin
            if (prev_cs) conv_word = (word_q.size() > 0) ? word_q.pop_front() : 16'h0000;
            if (prev_sclk && !adc_sclk) begin
                adc_sdo = conv_word[15 - fcnt];
                fcnt++;
            end
        end
        prev_sclk = adc_sclk;
        prev_cs   = adc_cs_n;
    end

    // reference model, cycle count from the start edge
    bit          m_act = 0, m_pend = 0;
    int          m_t = 0;
    logic [15:0] m_sh = '0;
    logic        e_cs = 1, e_sclk = 1, e_vld = 0, e_err = 0;
    logic [11:0] e_raw = '0;
    logic [15:0] e_word = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_t = 0;
            e_raw = '0; e_word = '0; e_err = 0;
        end else begin
            if (m_act) begin
                m_t++;
                if (start) m_pend = 1;
                if (m_t >= 2*H && m_t <= 32*H && (m_t % (2*H)) == 0)
                    m_sh = {m_sh[14:0], adc_sdo};
                if (m_t == T_END) begin
                    e_raw  = m_sh[11:0];
                    e_word = {{4{m_sh[11]}}, m_sh[11:0]};
                    e_err  = |m_sh[15:12];
                end
                if (m_t == T_IDLE) m_act = 0;
            end else if (start || m_pend) begin
                m_act = 1; m_t = 0; m_pend = 0;
            end
        end
        e_cs   = !(m_act && m_t < T_END);
        e_sclk = !(m_act && m_t >= H && m_t < T_END && ((m_t / H) % 2 == 1));
        e_vld  = m_act && (m_t == T_END);
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R3/R7 cs_n", {31'd0, adc_cs_n}, {31'd0, e_cs});
            check("R2/R3 sclk", {31'd0, adc_sclk}, {31'd0, e_sclk});
            check("R6 vld", {31'd0, sample_vld}, {31'd0, e_vld});
            check("R4 raw", {20'd0, sample_raw}, {20'd0, e_raw});
            check("R5 word", {16'd0, sample_word}, {16'd0, e_word});
            check("R9 lead_err", {31'd0, lead_err}, {31'd0, e_err});
            if (sample_vld) vld_seen++;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic one_frame(input logic [15:0] w, input logic [11:0] exp_raw,
                             input logic [15:0] exp_word, input logic exp_err);
        word_q.push_back(w);
        pulse_start();
        wait_cycles(T_END);
        check("R4 frame raw", {20'd0, sample_raw}, {20'd0, exp_raw});
        check("R5 frame word", {16'd0, sample_word}, {16'd0, exp_word});
        check("R9 frame err", {31'd0, lead_err}, {31'd0, exp_err});
        wait_cycles(GAPH * H + 4);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        wait_cycles(4);
        // R1 reset state
        check("R1 cs_n", {31'd0, adc_cs_n}, 32'd1);
        check("R1 sclk", {31'd0, adc_sclk}, 32'd1);
        check("R1 vld", {31'd0, sample_vld}, 32'd0);
        check("R1 word", {16'd0, sample_word}, 32'd0);
        check("R1 err", {31'd0, lead_err}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        wait_cycles(3);

        one_frame(16'h0123, 12'h123, 16'h0123, 1'b0);
        one_frame(16'h0ABC, 12'hABC, 16'hFABC, 1'b0);
        one_frame(16'h07FF, 12'h7FF, 16'h07FF, 1'b0);
        one_frame(16'h0800, 12'h800, 16'hF800, 1'b0);
        one_frame(16'h0FFF, 12'hFFF, 16'hFFFF, 1'b0);
        one_frame(16'h0000, 12'h000, 16'h0000, 1'b0);
        one_frame(16'h8123, 12'h123, 16'h0123, 1'b1);
        one_frame(16'h1FFF, 12'hFFF, 16'hFFFF, 1'b1);

        // R8: several requests during one frame open exactly one extra frame
        word_q.push_back(16'h0456);
        word_q.push_back(16'h0C01);
        vld_seen = 0;
        pulse_start();
        wait_cycles(10);
        pulse_start();
        wait_cycles(20);
        pulse_start();
        wait_cycles(3 * T_IDLE);
        check("R8 extra frame count", vld_seen, 32'd2);
        check("R8 second word", {16'd0, sample_word}, 32'h0000FC01);

        // R8: start held high runs frames back to back
        word_q.push_back(16'h0321);
        word_q.push_back(16'h0F00);
        @(negedge clk); start = 1'b1;
        wait_cycles(2 * T_IDLE);
        @(negedge clk); start = 1'b0;
        wait_cycles(3 * T_IDLE);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule